// File: doc/BRIEF.md
# Cycle-Stealing Single-Word DMA Engine

This engine moves a block of words between a peripheral and memory over one shared synchronous system bus, without a burst mode and without staying on the bus longer than one word. The CPU sets it up through a small write-only register port. It writes the direction, the fixed device port address, the first memory address and the number of words, and then sets the start bit. From then on the engine works alone.

For every word, the engine waits until the peripheral reports a word available (or free space), asks for the bus, and holds the request until the grant arrives. It then drives exactly two single-cycle bus transactions. The first reads the word into an internal holding register. The second writes that word to its destination. The engine then drops the request so the CPU can use the bus again. Granting the bus does not interrupt the CPU; the CPU only stalls if it needs the bus at that moment. After the last word, a sticky interrupt line rises and stays high until the CPU clears it.

Top module: `cs_dma_engine`

## Requirements
- R1: After reset, `busy`, `irq`, `bus_req` and `bus_valid` are all low.
- R2: A register write takes effect at the clock edge on which `cfg_wr_en` is high. `cfg_sel` picks the target register: 0 is control (bit 0 starts a transfer, bit 1 is the direction), 1 is the device address, 2 is the memory start address, 3 is the word count and 4 is status. A start with a non-zero count makes `busy` high in the next cycle.
- R3: `bus_req` rises only when the engine is busy and `dev_ready` was high in the cycle before. Once raised, it stays high until `bus_gnt` is seen.
- R4: With direction 0 (device to memory), each word takes two consecutive `bus_valid` cycles. The first is a read (`bus_we`=0) with `bus_space`=1 (device) at the device address. The second is a write (`bus_we`=1) with `bus_space`=0 (memory) at the current memory address, carrying the word returned by the first phase.
- R5: With direction 1 (memory to device), the two phases are swapped: a memory read at the current memory address, then a device write at the device address carrying that word.
- R6: After the write phase of each word, `bus_req` is low for at least one cycle.
- R7: The memory address advances by one after each word. The device address never changes during a transfer.
- R8: When the last word is written, `busy` falls and `irq` rises in the same cycle. `irq` stays high until a status write with bit 0 set, or until the next start.
- R9: While busy, writes to the control, device, memory or count registers are ignored. A second start during a transfer neither restarts it nor changes its addresses or its length.
- R10: A start with a word count of zero raises `irq` in the next cycle and leaves `busy` low, with no bus request and no bus transaction.
- R11: The first transfer phase begins only in the cycle after the grant was seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select for the write |
| cfg_wdata | input | DW | Register write data |
| dev_ready | input | 1 | Peripheral has a word (device to memory) or free space (memory to device) |
| bus_req | output | 1 | Bus request to the CPU/arbiter |
| bus_gnt | input | 1 | Bus grant, held while the request stays high |
| bus_valid | output | 1 | A bus transaction is driven this cycle |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_space | output | 1 | 1 = device port, 0 = memory |
| bus_addr | output | AW | Transaction address |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data, sampled at the end of a read cycle |
| busy | output | 1 | Transfer in progress |
| irq | output | 1 | Sticky completion interrupt |

## Verification
The bench slows the grant and pulls the peripheral's ready line low in the middle of a transfer. A design that requested the bus too early, or dropped the request before the grant arrived, would then disagree with the reference in the very first cycle. Both directions are run with known data. This catches swapped phases, a write carrying a stale holding register, or a memory pointer that advances at the wrong time or touches the device address. A zero-count start has to complete with no bus cycle at all; a design that decrements first would wrap the count and run for 65535 words. A start and address writes issued during a busy transfer must leave the programmed length and the destination untouched. The bench confirms this through the memory contents it holds.

// File: rtl/csdma_pkg.sv
// Shared definitions for the cycle-stealing DMA engine.
// Assumes: register select codes and the space encoding are fixed by the requirements.
package csdma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_REQ,
        ST_READ,
        ST_WRITE
    } seq_state_t;

    localparam logic [2:0] SEL_CTRL   = 3'd0;
    localparam logic [2:0] SEL_DEV    = 3'd1;
    localparam logic [2:0] SEL_MEM    = 3'd2;
    localparam logic [2:0] SEL_COUNT  = 3'd3;
    localparam logic [2:0] SEL_STATUS = 3'd4;

    localparam logic SPACE_MEM = 1'b0;
    localparam logic SPACE_DEV = 1'b1;

    localparam logic DIR_DEV2MEM = 1'b0;
    localparam logic DIR_MEM2DEV = 1'b1;

endpackage

// File: rtl/csdma_cfg.sv
// Register file of the DMA engine. It holds the direction, the device address,
// the memory pointer, the remaining word count and the sticky done flag.
// Assumes: word_done pulses once per completed word, only while busy.
// Programming writes are accepted only while idle; a status clear is accepted at any time.
module csdma_cfg
    import csdma_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [2:0]    wr_sel,
    input  logic [DW-1:0] wr_data,
    input  logic          busy,
    input  logic          word_done,
    output logic          start_go,
    output logic          dir,
    output logic [AW-1:0] dev_addr,
    output logic [AW-1:0] mem_addr,
    output logic          last_word,
    output logic          done
);

    localparam logic [CW-1:0] CNT_ONE = CW'(1);

    logic [CW-1:0] count;
    logic          idle_wr;
    logic          start_hit;
    logic          cnt_zero;
    logic          clr_hit;

    // Decode the register strobes and start conditions.
    always_comb begin
        idle_wr   = wr_en && !busy;
        start_hit = idle_wr && (wr_sel == SEL_CTRL) && wr_data[0];
        cnt_zero  = (count == '0);
        start_go  = start_hit && !cnt_zero;
        last_word = (count == CNT_ONE);
        clr_hit   = wr_en && (wr_sel == SEL_STATUS) && wr_data[0];
    end

    // Direction bit: loaded by a control write while idle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dir <= DIR_DEV2MEM;
        else if (idle_wr && wr_sel == SEL_CTRL)
            dir <= wr_data[1];
    end

    // Device port address: loaded while idle, fixed during a transfer.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dev_addr <= '0;
        else if (idle_wr && wr_sel == SEL_DEV)
            dev_addr <= wr_data[AW-1:0];
    end

    // Memory pointer: loaded while idle, advanced after every word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mem_addr <= '0;
        else if (word_done)
            mem_addr <= mem_addr + 1'b1;
        else if (idle_wr && wr_sel == SEL_MEM)
            mem_addr <= wr_data[AW-1:0];
    end

    // Remaining word count: loaded while idle, decremented after every word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (word_done)
            count <= count - 1'b1;
        else if (idle_wr && wr_sel == SEL_COUNT)
            count <= wr_data[CW-1:0];
    end

    // Sticky completion flag: a start reloads it, the last word sets it, a status write clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            done <= 1'b0;
        else if (start_hit)
            done <= cnt_zero;
        else if (word_done && last_word)
            done <= 1'b1;
        else if (clr_hit)
            done <= 1'b0;
    end

    // R7: the pointer moves by exactly one word after each completed word
    p_mem_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(word_done) |-> (mem_addr == AW'($past(mem_addr) + 1'b1)));

    // R7: the device address holds for the whole transfer
    p_dev_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(dev_addr));

    // R9: the count changes during a transfer only by word completion
    p_count_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !word_done) |=> $stable(count));

    // R10: a zero-count start finishes at once without going busy
    p_zero_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (start_hit && cnt_zero) |=> (done && !busy));

    // R8: the flag stays set until it is cleared or a new start arrives
    p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !clr_hit && !start_hit) |=> done);

endmodule

// File: rtl/csdma_seq.sv
// Bus sequencer of the DMA engine. For each word it waits for the peripheral,
// requests the bus, runs one read phase and one write phase, and releases the bus.
// Assumes: the arbiter holds bus_gnt while bus_req stays high, and read data is
// valid at the end of the read cycle.
module csdma_seq
    import csdma_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_go,
    input  logic          dir,
    input  logic [AW-1:0] dev_addr,
    input  logic [AW-1:0] mem_addr,
    input  logic          last_word,
    input  logic          dev_ready,
    input  logic          bus_gnt,
    input  logic [DW-1:0] bus_rdata,
    output logic          bus_req,
    output logic          bus_valid,
    output logic          bus_we,
    output logic          bus_space,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    output logic          word_done,
    output logic          busy
);

    seq_state_t    state;
    logic [DW-1:0] hold;
    logic          first_space;

    // Per-word state machine: wait for ready, request, read, write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE:  if (start_go)  state <= ST_WAIT;
                ST_WAIT:  if (dev_ready) state <= ST_REQ;
                ST_REQ:   if (bus_gnt)   state <= ST_READ;
                ST_READ:                 state <= ST_WRITE;
                ST_WRITE:                state <= last_word ? ST_IDLE : ST_WAIT;
                default:                 state <= ST_IDLE;
            endcase
        end
    end

    // One-word holding register, loaded at the end of the read phase.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold <= '0;
        else if (state == ST_READ)
            hold <= bus_rdata;
    end

    // Drive the bus from the state and the direction.
    always_comb begin
        first_space = (dir == DIR_DEV2MEM) ? SPACE_DEV : SPACE_MEM;
        bus_req     = (state == ST_REQ) || (state == ST_READ) || (state == ST_WRITE);
        bus_valid   = (state == ST_READ) || (state == ST_WRITE);
        bus_we      = (state == ST_WRITE);
        bus_space   = (state == ST_WRITE) ? ~first_space : first_space;
        bus_addr    = (bus_space == SPACE_DEV) ? dev_addr : mem_addr;
        bus_wdata   = (state == ST_WRITE) ? hold : '0;
        word_done   = (state == ST_WRITE);
        busy        = (state != ST_IDLE);
    end

    // R3: a pending request is not withdrawn before the grant
    p_req_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REQ && !bus_gnt) |=> bus_req);

    // R3: a request starts only after the peripheral was ready
    p_req_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> $past(dev_ready));

    // R4: a read phase is always followed by a write phase
    p_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_we) |=> (bus_valid && bus_we));

    // R6: the bus is released after each write phase
    p_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_we) |=> !bus_req);

    // R11: transfer phases begin only after a grant was seen
    p_first_phase_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_valid) |-> $past(bus_gnt));

endmodule

// File: rtl/cs_dma_engine.sv
// Top of the single-channel cycle-stealing DMA engine: a register file and a
// bus sequencer wired together. The interrupt is the sticky done flag.
// Assumes: one shared single-word bus with request/grant arbitration.
module cs_dma_engine
    import csdma_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr_en,
    input  logic [2:0]    cfg_sel,
    input  logic [DW-1:0] cfg_wdata,
    input  logic          dev_ready,
    output logic          bus_req,
    input  logic          bus_gnt,
    output logic          bus_valid,
    output logic          bus_we,
    output logic          bus_space,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata,
    output logic          busy,
    output logic          irq
);

    logic          start_go;
    logic          dir;
    logic [AW-1:0] dev_addr;
    logic [AW-1:0] mem_addr;
    logic          last_word;
    logic          word_done;
    logic          done;

    csdma_cfg #(.AW(AW), .DW(DW), .CW(CW)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_wr_en),
        .wr_sel    (cfg_sel),
        .wr_data   (cfg_wdata),
        .busy      (busy),
        .word_done (word_done),
        .start_go  (start_go),
        .dir       (dir),
        .dev_addr  (dev_addr),
        .mem_addr  (mem_addr),
        .last_word (last_word),
        .done      (done)
    );

    csdma_seq #(.AW(AW), .DW(DW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_go  (start_go),
        .dir       (dir),
        .dev_addr  (dev_addr),
        .mem_addr  (mem_addr),
        .last_word (last_word),
        .dev_ready (dev_ready),
        .bus_gnt   (bus_gnt),
        .bus_rdata (bus_rdata),
        .bus_req   (bus_req),
        .bus_valid (bus_valid),
        .bus_we    (bus_we),
        .bus_space (bus_space),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .word_done (word_done),
        .busy      (busy)
    );

    // Interrupt output is the sticky flag.
    always_comb irq = done;

    // R8: completion drops busy in the same cycle that irq rises
    p_irq_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> !busy);

endmodule

// File: tb/sim_cs_dma_engine.sv
`timescale 1ns/1ps
module sim_cs_dma_engine;
    localparam int AW = 16;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic          cfg_wr_en = 1'b0;
    logic [2:0]    cfg_sel = '0;
    logic [DW-1:0] cfg_wdata = '0;
    logic          dev_ready = 1'b0;
    logic          bus_gnt = 1'b0;
    logic [DW-1:0] bus_rdata;
    logic          bus_req, bus_valid, bus_we, bus_space, busy, irq;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;

    cs_dma_engine #(.AW(AW), .DW(DW), .CW(16)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .dev_ready(dev_ready), .bus_req(bus_req),
        .bus_gnt(bus_gnt), .bus_valid(bus_valid), .bus_we(bus_we),
        .bus_space(bus_space), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .busy(busy), .irq(irq)
    );

    int total = 0;
    int bad = 0;
    logic [DW-1:0] mem [0:63];
    logic [DW-1:0] sink_q [$];
    int dev_rd_count = 0;
    int valid_seen = 0;
    int gdelay = 0;
    int req_wait = 0;

    // reference model state: 0 idle, 1 wait, 2 request, 3 read, 4 write
    int m_st = 0;
    int m_dir = 0;
    int m_dev = 0;
    int m_mem = 0;
    int m_cnt = 0;
    int m_done = 0;
    int m_latch = 0;

    task automatic chk(input string tag, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // memory and device model answering reads
    always_comb begin
        if (bus_space) bus_rdata = DW'(16'hA000 + dev_rd_count);
        else           bus_rdata = mem[bus_addr[5:0]];
    end

    // per-cycle compare, bus side effects, arbiter and model step
    always @(negedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_dir = 0; m_dev = 0; m_mem = 0; m_cnt = 0; m_done = 0; m_latch = 0;
            bus_gnt = 1'b0; req_wait = 0;
        end else begin
            int e_space;
            e_space = (m_st == 4) ? (m_dir == 0 ? 0 : 1) : (m_dir == 0 ? 1 : 0);
            chk("R2 busy", busy, m_st != 0);
            chk("R8 irq", irq, m_done);
            chk("R3 R6 bus_req", bus_req, m_st >= 2);
            chk("R4 R11 bus_valid", bus_valid, m_st >= 3);
            if (m_st >= 3) begin
                chk("R4 bus_we", bus_we, m_st == 4);
                chk(m_dir == 0 ? "R4 bus_space" : "R5 bus_space", bus_space, e_space);
                chk("R7 bus_addr", bus_addr, e_space ? m_dev : m_mem);
                if (m_st == 4) chk(m_dir == 0 ? "R4 bus_wdata" : "R5 bus_wdata", bus_wdata, m_latch);
            end
            if (bus_valid) valid_seen++;
            if (bus_valid && bus_we && !bus_space) mem[bus_addr[5:0]] = bus_wdata;
            if (bus_valid && bus_we && bus_space) sink_q.push_back(bus_wdata);
            // arbiter: grant after gdelay cycles of request, held while requested
            if (bus_req) req_wait++; else req_wait = 0;
            bus_gnt = bus_req && (req_wait > gdelay);
            // model step with the inputs the design sees at the next edge
            if (m_st == 4 && m_dir == 0) dev_rd_count++;
            if (cfg_wr_en && cfg_sel == 3'd4 && cfg_wdata[0]) m_done = 0;
            if (cfg_wr_en && m_st == 0) begin
                case (cfg_sel)
                    3'd0: begin
                        m_dir = cfg_wdata[1];
                        if (cfg_wdata[0]) begin
                            m_done = (m_cnt == 0);
                            if (m_cnt != 0) m_st = 1;
                        end
                    end
                    3'd1: m_dev = cfg_wdata;
                    3'd2: m_mem = cfg_wdata;
                    3'd3: m_cnt = cfg_wdata;
                    default: ;
                endcase
            end else begin
                case (m_st)
                    1: if (dev_ready) m_st = 2;
                    2: if (bus_gnt) m_st = 3;
                    3: begin
                        m_latch = (m_dir == 0) ? (16'hA000 + dev_rd_count) : mem[m_mem[5:0]];
                        m_st = 4;
                    end
                    4: begin
                        m_cnt = m_cnt - 1;
                        m_mem = (m_mem + 1) & 16'hFFFF;
                        if (m_cnt == 0) begin m_done = 1; m_st = 0; end
                        else m_st = 1;
                    end
                    default: ;
                endcase
            end
        end
    end

    task automatic cfg_write(input logic [2:0] s, input logic [DW-1:0] d);
        @(posedge clk); #1;
        cfg_wr_en = 1'b1; cfg_sel = s; cfg_wdata = d;
        @(posedge clk); #1;
        cfg_wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 2000 && m_st != 0; i++) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(5.0 * 150000);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int v0;
        for (int i = 0; i < 64; i++) mem[i] = DW'(16'hD000 + i);
        for (int i = 0; i < 3; i++) mem[32 + i] = DW'(16'hB000 + i);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy", busy, 0); chk("R1 irq", irq, 0);
        chk("R1 bus_req", bus_req, 0); chk("R1 bus_valid", bus_valid, 0);

        // device to memory, four words, immediate grant
        dev_ready = 1'b1; gdelay = 0;
        cfg_write(3'd1, 16'h0007);
        cfg_write(3'd2, 16'h0010);
        cfg_write(3'd3, 16'd4);
        cfg_write(3'd0, 16'h0001);
        @(negedge clk);
        chk("R2 busy after start", busy, 1);
        wait_idle();
        for (int i = 0; i < 4; i++) chk("R4 memory word", mem[16 + i], 16'hA000 + i);
        chk("R7 untouched beyond block", mem[20], 16'hD014);
        chk("R8 irq after last word", irq, 1);
        repeat (3) @(negedge clk);
        chk("R8 irq sticky", irq, 1);
        cfg_write(3'd4, 16'h0001);
        @(negedge clk);
        chk("R8 irq cleared", irq, 0);

        // memory to device, three words, slow grant and late ready
        dev_ready = 1'b0; gdelay = 2;
        cfg_write(3'd1, 16'h0033);
        cfg_write(3'd2, 16'h0020);
        cfg_write(3'd3, 16'd3);
        cfg_write(3'd0, 16'h0003);
        repeat (5) @(negedge clk);
        chk("R3 no request without ready", bus_req, 0);
        @(posedge clk); #1 dev_ready = 1'b1;
        wait_idle();
        chk("R5 sink count", sink_q.size(), 3);
        for (int i = 0; i < 3 && i < sink_q.size(); i++) chk("R5 device word", sink_q[i], 16'hB000 + i);
        cfg_write(3'd4, 16'h0001);

        // zero count completes with no bus activity
        cfg_write(3'd3, 16'd0);
        v0 = valid_seen;
        cfg_write(3'd0, 16'h0001);
        chk("R10 irq at once", irq, 1);
        chk("R10 not busy", busy, 0);
        repeat (4) @(negedge clk);
        chk("R10 no bus cycles", valid_seen, v0);
        chk("R10 no request", bus_req, 0);
        cfg_write(3'd4, 16'h0001);

        // writes during a busy transfer are ignored
        dev_ready = 1'b0; gdelay = 1;
        cfg_write(3'd1, 16'h0002);
        cfg_write(3'd2, 16'h0028);
        cfg_write(3'd3, 16'd3);
        cfg_write(3'd0, 16'h0001);
        cfg_write(3'd2, 16'h0030);
        cfg_write(3'd3, 16'd9);
        cfg_write(3'd0, 16'h0003);
        @(posedge clk); #1 dev_ready = 1'b1;
        wait_idle();
        for (int i = 0; i < 3; i++) chk("R9 words at original pointer", mem[40 + i], 16'hA004 + i);
        chk("R9 length kept", mem[43], 16'hD02B);
        chk("R9 rewritten pointer unused", mem[48], 16'hD030);
        chk("R9 direction kept", sink_q.size(), 3);
        chk("R8 irq at end", irq, 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule